// File: doc/BRIEF.md
# Chained-ID Test Access Port Controller

This block is a boundary-scan style test access port that runs from a fast system clock. The scan pins (test clock, mode select, serial data in and an active-low test reset) are brought into the system clock domain through two-flop synchronizers. A rising edge of the synchronized test clock advances a 16-state TAP controller. On each such edge the controller first carries out the action of the state it is in, then moves to the next state chosen by the mode-select level seen on that same edge.

Two scan paths sit behind the controller. The first is a 46-bit instruction shift register that feeds a latched instruction word. The second is a 197-bit data chain that stands in for six devices in a daisy chain. Each device has a 32-bit identity code, and these codes are placed at irregular positions along the chain. The identity image is written into the chain on every controller edge spent in the reset state. It is written again at capture time, but only when one particular instruction is latched.

Two configuration instructions each turn an Update-DR into a 42-bit word on an output port. The word comes with a single-cycle valid strobe and a flag that tells which of the two instructions was active.

Top module: `jtag_chain_tap`

## Requirements
- R1: Every rising edge of the synchronized `tck` moves the controller along the standard 16-state TAP graph, selected by `tms`. Five edges with `tms`=1 reach Test-Logic-Reset from any state, and so does `tms`=1 in Select-IR.
- R2: While `tck` holds its level, changes on `tms` and `tdi` alter neither the state nor any register, and `tdo` and the configuration outputs stay as they were.
- R3: An edge in Capture-IR writes 1 to instruction shift bit 0 and 0 to bit 1, and leaves bits 45..2 unchanged.
- R4: An edge in Shift-IR or Shift-DR shifts the selected register one place toward bit 0. The old bit 0 appears on `tdo` and `tdi` enters the top bit. In all other states `tdo` keeps its value.
- R5: An edge in Update-IR copies all 46 shift bits into the instruction word. Only an exact 46-bit match selects an instruction.
- R6: An edge in Test-Logic-Reset loads the data chain with zeros and six identity codes. Device k is taken from `id_codes[32k+31:32k]`. Its MSB lands at chain bit 194-32k for k=0..3 and at bit 193-32k for k=4..5, so the codes start at distances 2, 34, 66, 98, 131 and 163 below bit 196.
- R7: An edge in Capture-DR reloads that identity image only when the instruction word equals 46'h06318fc63fff. With any other instruction, capture leaves the chain unchanged.
- R8: An edge in Update-DR with configuration opcode 0 or 1 latched gives a one-clock `cfg_valid` pulse. It also sets `cfg_data` to chain bits 196..155 and `cfg_sel` to 0 or 1. Any other instruction gives no pulse.
- R9: A low `trst_n` forces Test-Logic-Reset without needing a `tck` edge. The instruction word and `tdo` are not changed by it.
- R10: A low `rst_n` clears the controller to Test-Logic-Reset. It also sets the instruction word, both shift registers, `tdo`, `cfg_valid`, `cfg_data` and `cfg_sel` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every scan pin |
| rst_n | input | 1 | Active-low asynchronous system reset |
| tck | input | 1 | Test clock, asynchronous |
| tms | input | 1 | Test mode select, asynchronous |
| tdi | input | 1 | Serial scan data in, asynchronous |
| trst_n | input | 1 | Active-low test reset, asynchronous assert |
| id_codes | input | N_DEV*ID_W (192) | Identity codes, device k in bits [32k+31:32k] |
| tdo | output | 1 | Serial scan data out, registered |
| cfg_valid | output | 1 | One-clock strobe for a configuration word |
| cfg_data | output | CFG_W (42) | Configuration word taken from the chain top |
| cfg_sel | output | 1 | 0 for configuration opcode 0, 1 for opcode 1 |

## Verification
The bench builds the block with its default geometry: 46 instruction bits, a 197-bit chain, six 32-bit devices with the one-bit skew after device 3, and a 42-bit word. It also passes the three opcodes explicitly. With these values the irregular step between the fourth and fifth codes is visible in a full chain readout. The same holds for the 42-bit word sliced from the chain top and for the near-miss opcode that differs from a configuration opcode only in bit 45. The two-stage synchronizer depth sets the latency the bench waits out between a test-clock rise and its check.

// File: rtl/jtag_chain_pkg.sv
package jtag_chain_pkg;

   typedef enum logic [3:0] {
      ST_RESET    = 4'd0,
      ST_IDLE     = 4'd1,
      ST_DR_SEL   = 4'd2,
      ST_DR_CAP   = 4'd3,
      ST_DR_SHIFT = 4'd4,
      ST_DR_EXIT1 = 4'd5,
      ST_DR_PAUSE = 4'd6,
      ST_DR_EXIT2 = 4'd7,
      ST_DR_UPD   = 4'd8,
      ST_IR_SEL   = 4'd9,
      ST_IR_CAP   = 4'd10,
      ST_IR_SHIFT = 4'd11,
      ST_IR_EXIT1 = 4'd12,
      ST_IR_PAUSE = 4'd13,
      ST_IR_EXIT2 = 4'd14,
      ST_IR_UPD   = 4'd15
   } tap_state_e;

   // Successor of a controller state for a given mode-select level.
   function automatic tap_state_e tap_next(input tap_state_e cur, input logic sel);
      tap_state_e nxt;
      case (cur)
         ST_RESET:    nxt = sel ? ST_RESET    : ST_IDLE;
         ST_IDLE:     nxt = sel ? ST_DR_SEL   : ST_IDLE;
         ST_DR_SEL:   nxt = sel ? ST_IR_SEL   : ST_DR_CAP;
         ST_DR_CAP:   nxt = sel ? ST_DR_EXIT1 : ST_DR_SHIFT;
         ST_DR_SHIFT: nxt = sel ? ST_DR_EXIT1 : ST_DR_SHIFT;
         ST_DR_EXIT1: nxt = sel ? ST_DR_UPD   : ST_DR_PAUSE;
         ST_DR_PAUSE: nxt = sel ? ST_DR_EXIT2 : ST_DR_PAUSE;
         ST_DR_EXIT2: nxt = sel ? ST_DR_UPD   : ST_DR_SHIFT;
         ST_DR_UPD:   nxt = sel ? ST_DR_SEL   : ST_IDLE;
         ST_IR_SEL:   nxt = sel ? ST_RESET    : ST_IR_CAP;
         ST_IR_CAP:   nxt = sel ? ST_IR_EXIT1 : ST_IR_SHIFT;
         ST_IR_SHIFT: nxt = sel ? ST_IR_EXIT1 : ST_IR_SHIFT;
         ST_IR_EXIT1: nxt = sel ? ST_IR_UPD   : ST_IR_PAUSE;
         ST_IR_PAUSE: nxt = sel ? ST_IR_EXIT2 : ST_IR_PAUSE;
         ST_IR_EXIT2: nxt = sel ? ST_IR_UPD   : ST_IR_SHIFT;
         ST_IR_UPD:   nxt = sel ? ST_DR_SEL   : ST_IDLE;
         default:     nxt = ST_RESET;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/jtag_in_sync.sv
// Brings the asynchronous scan pins into the system clock domain and flags
// one-cycle rising edges of the synchronized test clock.
module jtag_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tck_i,
   input  logic tms_i,
   input  logic tdi_i,
   output logic step_o,
   output logic tms_o,
   output logic tdi_o
);
   localparam int NSIG = 3;

   if (STAGES < 2) begin : g_bad_stages
      $error("jtag_in_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][NSIG-1:0] stage_q;
   logic                        tck_prev_q;
   logic [NSIG-1:0]             pins;

   assign pins = {tdi_i, tms_i, tck_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q    <= '0;
         tck_prev_q <= 1'b0;
      end else begin
         stage_q    <= {stage_q[STAGES-2:0], pins};
         tck_prev_q <= stage_q[STAGES-1][0];
      end
   end

   assign step_o = stage_q[STAGES-1][0] & ~tck_prev_q;
   assign tms_o  = stage_q[STAGES-1][1];
   assign tdi_o  = stage_q[STAGES-1][2];
endmodule

// File: rtl/jtag_tap_fsm.sv
// 16-state controller. The test reset asserts asynchronously and is released
// through a reset synchronizer on the system clock.
module jtag_tap_fsm
   import jtag_chain_pkg::*;
#(
   parameter int RST_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trst_n,
   input  logic       step,
   input  logic       tms,
   output tap_state_e state_o
);
   if (RST_STAGES < 2) begin : g_bad_rst
      $error("jtag_tap_fsm: RST_STAGES must be at least 2");
   end

   logic                  any_rst_n;
   logic [RST_STAGES-1:0] rel_q;
   logic                  tap_rst_n;
   tap_state_e            state_q;

   assign any_rst_n = rst_n & trst_n;

   always_ff @(posedge clk or negedge any_rst_n) begin
      if (!any_rst_n) rel_q <= '0;
      else            rel_q <= {rel_q[RST_STAGES-2:0], 1'b1};
   end

   assign tap_rst_n = rel_q[RST_STAGES-1];

   always_ff @(posedge clk or negedge tap_rst_n) begin
      if (!tap_rst_n)  state_q <= ST_RESET;
      else if (step)   state_q <= tap_next(state_q, tms);
   end

   assign state_o = state_q;
endmodule

// File: rtl/jtag_ir_path.sv
// Instruction shift register and latched instruction word.
module jtag_ir_path
   import jtag_chain_pkg::*;
#(
   parameter int             IR_W     = 46,
   parameter logic [IR_W-1:0] IR_RESET = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   input  tap_state_e      state,
   input  logic            tdi,
   output logic            shift_out,
   output logic [IR_W-1:0] ir_word
);
   if (IR_W < 2) begin : g_bad_ir
      $error("jtag_ir_path: IR_W must be at least 2");
   end

   logic [IR_W-1:0] sh_q;
   logic [IR_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         word_q <= IR_RESET;
      end else if (step) begin
         case (state)
            ST_IR_CAP:   sh_q[1:0] <= 2'b01;
            ST_IR_SHIFT: sh_q      <= {tdi, sh_q[IR_W-1:1]};
            ST_IR_UPD:   word_q    <= sh_q;
            default: ;
         endcase
      end
   end

   assign shift_out = sh_q[0];
   assign ir_word   = word_q;
endmodule

// File: rtl/jtag_dr_chain.sv
// Chained data register: identity image load, serial shift and export of the
// configuration word on update.
module jtag_dr_chain
   import jtag_chain_pkg::*;
#(
   parameter int              IR_W       = 46,
   parameter int              DR_W       = 197,
   parameter int              N_DEV      = 6,
   parameter int              ID_W       = 32,
   parameter int              ID_BASE    = 2,
   parameter int              SKEW_IDX   = 4,
   parameter int              CFG_W      = 42,
   parameter logic [IR_W-1:0] OP_IDLOAD  = 46'h06318fc63fff,
   parameter logic [IR_W-1:0] OP_CFG0    = 46'h0a318fc63fff,
   parameter logic [IR_W-1:0] OP_CFG1    = 46'h0e318fc63fff
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  step,
   input  tap_state_e            state,
   input  logic                  tdi,
   input  logic [IR_W-1:0]       ir_word,
   input  logic [N_DEV*ID_W-1:0] id_codes,
   output logic                  shift_out,
   output logic                  cfg_valid,
   output logic [CFG_W-1:0]      cfg_data,
   output logic                  cfg_sel
);
   localparam int SKEW_ADD = (SKEW_IDX < N_DEV) ? 1 : 0;
   localparam int NEED_W   = ID_BASE + N_DEV * ID_W + SKEW_ADD;

   if (NEED_W > DR_W) begin : g_bad_fit
      $error("jtag_dr_chain: identity codes do not fit in DR_W");
   end
   if (CFG_W > DR_W || CFG_W < 1) begin : g_bad_cfg
      $error("jtag_dr_chain: CFG_W out of range");
   end
   if (OP_CFG0 == OP_CFG1) begin : g_bad_ops
      $error("jtag_dr_chain: configuration opcodes must differ");
   end

   // One placed copy per device; the image is their union.
   logic [DR_W-1:0] placed [N_DEV];
   logic [DR_W-1:0] id_image;

   for (genvar g = 0; g < N_DEV; g++) begin : g_place
      localparam int TOP_B = DR_W - 1 - ID_BASE - g * ID_W - ((g >= SKEW_IDX) ? 1 : 0);
      localparam int LOW_B = TOP_B - ID_W + 1;
      assign placed[g] = {{(DR_W-ID_W){1'b0}}, id_codes[g*ID_W +: ID_W]} << LOW_B;
   end

   always_comb begin
      id_image = '0;
      for (int k = 0; k < N_DEV; k++) id_image = id_image | placed[k];
   end

   logic            hit_id;
   logic            hit_c0;
   logic            hit_c1;
   logic [DR_W-1:0] sh_q;

   assign hit_id = (ir_word == OP_IDLOAD);
   assign hit_c0 = (ir_word == OP_CFG0);
   assign hit_c1 = (ir_word == OP_CFG1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q      <= '0;
         cfg_valid <= 1'b0;
         cfg_data  <= '0;
         cfg_sel   <= 1'b0;
      end else begin
         cfg_valid <= 1'b0;
         if (step) begin
            case (state)
               ST_RESET:    sh_q <= id_image;
               ST_DR_CAP:   if (hit_id) sh_q <= id_image;
               ST_DR_SHIFT: sh_q <= {tdi, sh_q[DR_W-1:1]};
               ST_DR_UPD: begin
                  if (hit_c0 || hit_c1) begin
                     cfg_valid <= 1'b1;
                     cfg_data  <= sh_q[DR_W-1 -: CFG_W];
                     cfg_sel   <= hit_c1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign shift_out = sh_q[0];
endmodule

// File: rtl/jtag_chain_tap.sv
module jtag_chain_tap
   import jtag_chain_pkg::*;
#(
   parameter int              SYNC_STAGES = 2,
   parameter int              IR_W        = 46,
   parameter int              DR_W        = 197,
   parameter int              N_DEV       = 6,
   parameter int              ID_W        = 32,
   parameter int              ID_BASE     = 2,
   parameter int              SKEW_IDX    = 4,
   parameter int              CFG_W       = 42,
   parameter logic [IR_W-1:0] OP_IDLOAD   = 46'h06318fc63fff,
   parameter logic [IR_W-1:0] OP_CFG0     = 46'h0a318fc63fff,
   parameter logic [IR_W-1:0] OP_CFG1     = 46'h0e318fc63fff
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tck,
   input  logic                  tms,
   input  logic                  tdi,
   input  logic                  trst_n,
   input  logic [N_DEV*ID_W-1:0] id_codes,
   output logic                  tdo,
   output logic                  cfg_valid,
   output logic [CFG_W-1:0]      cfg_data,
   output logic                  cfg_sel
);
   logic            tck_step;
   logic            tms_s;
   logic            tdi_s;
   tap_state_e      tap_state;
   logic            ir_bit;
   logic            dr_bit;
   logic [IR_W-1:0] ir_word;

   jtag_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .tck_i  (tck),
      .tms_i  (tms),
      .tdi_i  (tdi),
      .step_o (tck_step),
      .tms_o  (tms_s),
      .tdi_o  (tdi_s)
   );

   jtag_tap_fsm #(.RST_STAGES(SYNC_STAGES)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .trst_n  (trst_n),
      .step    (tck_step),
      .tms     (tms_s),
      .state_o (tap_state)
   );

   jtag_ir_path #(.IR_W(IR_W), .IR_RESET('0)) u_ir (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (tck_step),
      .state     (tap_state),
      .tdi       (tdi_s),
      .shift_out (ir_bit),
      .ir_word   (ir_word)
   );

   jtag_dr_chain #(
      .IR_W      (IR_W),
      .DR_W      (DR_W),
      .N_DEV     (N_DEV),
      .ID_W      (ID_W),
      .ID_BASE   (ID_BASE),
      .SKEW_IDX  (SKEW_IDX),
      .CFG_W     (CFG_W),
      .OP_IDLOAD (OP_IDLOAD),
      .OP_CFG0   (OP_CFG0),
      .OP_CFG1   (OP_CFG1)
   ) u_dr (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (tck_step),
      .state     (tap_state),
      .tdi       (tdi_s),
      .ir_word   (ir_word),
      .id_codes  (id_codes),
      .shift_out (dr_bit),
      .cfg_valid (cfg_valid),
      .cfg_data  (cfg_data),
      .cfg_sel   (cfg_sel)
   );

   // Serial output register: only the two shift states drive it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdo <= 1'b0;
      end else if (tck_step) begin
         if (tap_state == ST_IR_SHIFT)      tdo <= ir_bit;
         else if (tap_state == ST_DR_SHIFT) tdo <= dr_bit;
      end
   end
endmodule

// File: rtl/jtag_chain_tap_chk.sv
module jtag_chain_tap_chk
   import jtag_chain_pkg::*;
#(
   parameter int IR_W = 46
) (
   input logic            clk,
   input logic            rst_n,
   input logic            trst_n,
   input logic            step,
   input tap_state_e      state,
   input logic            ir_bit,
   input logic [IR_W-1:0] ir_word,
   input logic            tdo,
   input logic            cfg_valid
);
   // R2: without a test-clock rise only the test reset may move the state
   p_hold_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(state) || state == ST_RESET));

   // R2: the instruction word never moves without a rise
   p_hold_ir_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(ir_word));

   // R3: capture puts a 1 at the instruction shift output bit
   p_cap_ir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && state == ST_IR_CAP) |=> ir_bit);

   // R4: tdo changes only after a rise in one of the shift states
   p_tdo_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tdo) |-> ($past(step) &&
                         ($past(state) == ST_IR_SHIFT || $past(state) == ST_DR_SHIFT)));

   // R5: the instruction word changes only from Update-IR
   p_ir_upd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ir_word) |-> ($past(step) && $past(state) == ST_IR_UPD));

   // R8: the strobe follows a rise in Update-DR and lasts one cycle
   p_cfg_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> ($past(step) && $past(state) == ST_DR_UPD));

   p_cfg_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |=> !cfg_valid);

   // R9: a held test reset keeps the controller in Test-Logic-Reset
   p_trst_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!trst_n && $past(!trst_n)) |-> state == ST_RESET);
endmodule

bind jtag_chain_tap jtag_chain_tap_chk #(.IR_W(IR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .trst_n    (trst_n),
   .step      (tck_step),
   .state     (tap_state),
   .ir_bit    (ir_bit),
   .ir_word   (ir_word),
   .tdo       (tdo),
   .cfg_valid (cfg_valid)
);

// File: tb/tb_jtag_chain_tap.sv
module tb_jtag_chain_tap;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 4;
   localparam logic [45:0] OP_ID = 46'h06318fc63fff;
   localparam logic [45:0] OP_C0 = 46'h0a318fc63fff;
   localparam logic [45:0] OP_C1 = 46'h0e318fc63fff;

   // Model state numbering (graph of R1)
   localparam int S_TLR = 0,  S_RTI = 1,  S_SDR = 2,  S_CDR = 3,
                  S_SHD = 4,  S_E1D = 5,  S_PD  = 6,  S_E2D = 7,
                  S_UDR = 8,  S_SIR = 9,  S_CIR = 10, S_SHI = 11,
                  S_E1I = 12, S_PI  = 13, S_E2I = 14, S_UIR = 15;

   logic         clk = 1'b0;
   logic         rst_n, tck, tms, tdi, trst_n;
   logic [191:0] ids;
   logic         tdo, cfg_valid, cfg_sel;
   logic [41:0]  cfg_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   jtag_chain_tap #(
      .OP_IDLOAD (OP_ID),
      .OP_CFG0   (OP_C0),
      .OP_CFG1   (OP_C1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n),
      .id_codes(ids), .tdo(tdo), .cfg_valid(cfg_valid), .cfg_data(cfg_data),
      .cfg_sel(cfg_sel)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // Reference model
   int           m_state;
   logic [45:0]  m_irsr, m_ir;
   logic [196:0] m_dr;
   logic         m_tdo;
   int           exp_cnt;
   logic [41:0]  exp_data;
   logic         exp_sel;

   // Strobe monitor
   int          cfg_cnt = 0;
   logic [41:0] cfg_last = '0;
   logic        cfg_last_sel = 1'b0;
   always @(negedge clk) if (cfg_valid === 1'b1) begin
      cfg_cnt++;
      cfg_last     = cfg_data;
      cfg_last_sel = cfg_sel;
   end

   function automatic logic [196:0] layout(input logic [191:0] c);
      logic [196:0] r = '0;
      int off;
      for (int i = 0; i < 6; i++) begin
         off = 2 + 32 * i + ((i >= 4) ? 1 : 0);
         r[196 - off -: 32] = c[32 * i +: 32];
      end
      return r;
   endfunction

   function automatic int nxt(input int s, input bit m);
      case (s)
         S_TLR: return m ? S_TLR : S_RTI;
         S_RTI: return m ? S_SDR : S_RTI;
         S_SDR: return m ? S_SIR : S_CDR;
         S_CDR: return m ? S_E1D : S_SHD;
         S_SHD: return m ? S_E1D : S_SHD;
         S_E1D: return m ? S_UDR : S_PD;
         S_PD:  return m ? S_E2D : S_PD;
         S_E2D: return m ? S_UDR : S_SHD;
         S_UDR: return m ? S_SDR : S_RTI;
         S_SIR: return m ? S_TLR : S_CIR;
         S_CIR: return m ? S_E1I : S_SHI;
         S_SHI: return m ? S_E1I : S_SHI;
         S_E1I: return m ? S_UIR : S_PI;
         S_PI:  return m ? S_E2I : S_PI;
         S_E2I: return m ? S_UIR : S_SHI;
         default: return m ? S_SDR : S_RTI;
      endcase
   endfunction

   task automatic model_rise(input bit m, input bit d);
      case (m_state)
         S_TLR: m_dr = layout(ids);
         S_CDR: if (m_ir == OP_ID) m_dr = layout(ids);
         S_SHD: begin m_tdo = m_dr[0]; m_dr = {d, m_dr[196:1]}; end
         S_UDR: if (m_ir == OP_C0 || m_ir == OP_C1) begin
                   exp_cnt++;
                   exp_data = m_dr[196:155];
                   exp_sel  = (m_ir == OP_C1);
                end
         S_CIR: m_irsr[1:0] = 2'b01;
         S_SHI: begin m_tdo = m_irsr[0]; m_irsr = {d, m_irsr[45:1]}; end
         S_UIR: m_ir = m_irsr;
         default: ;
      endcase
      m_state = nxt(m_state, m);
   endtask

   task automatic chk(input bit ok, input string req, input logic [255:0] act,
                      input logic [255:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One test-clock period; compared against the model once it has settled.
   task automatic tck_cycle(input bit m, input bit d);
      @(negedge clk);
      tck = 1'b0; tms = m; tdi = d;
      repeat (HALF) @(negedge clk);
      tck = 1'b1;
      repeat (HALF) @(negedge clk);
      model_rise(m, d);
      chk(tdo === m_tdo, "R4 tdo per edge", 256'(tdo), 256'(m_tdo));
      chk(cfg_cnt == exp_cnt, "R8 strobe count", 256'(cfg_cnt), 256'(exp_cnt));
      if (exp_cnt > 0)
         chk(cfg_last === exp_data && cfg_last_sel === exp_sel, "R8 word per edge",
             256'({cfg_last_sel, cfg_last}), 256'({exp_sel, exp_data}));
   endtask

   task automatic scan_ir(input logic [45:0] v, output logic [45:0] o);
      tck_cycle(1, 0); tck_cycle(1, 0); tck_cycle(0, 0); tck_cycle(0, 0);
      for (int i = 0; i < 46; i++) begin
         tck_cycle(i == 45, v[i]);
         o[i] = tdo;
      end
      tck_cycle(1, 0); tck_cycle(0, 0);
   endtask

   task automatic scan_dr(input logic [196:0] v, input bit pause, output logic [196:0] o);
      tck_cycle(1, 0); tck_cycle(0, 0); tck_cycle(0, 0);
      for (int i = 0; i < 197; i++) begin
         tck_cycle(i == 196 || (pause && i == 99), v[i]);
         o[i] = tdo;
         if (pause && i == 99) begin
            tck_cycle(0, 0); tck_cycle(0, 0); tck_cycle(1, 0); tck_cycle(0, 0);
         end
      end
      tck_cycle(1, 0); tck_cycle(0, 0);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [45:0]  io;
      logic [196:0] dout, d1, d2;
      logic [191:0] ids2, ids3;
      int           cnt_before;
      logic         tdo_before;

      d1   = {5'h15, {6{32'h9e3779b9}}};
      d2   = {5'h0a, {6{32'h7f4a7c15}}};
      ids  = {32'h6666_0006, 32'h5555_0005, 32'h4444_0004,
              32'h3333_0003, 32'h2222_0002, 32'h8111_0001};
      ids2 = {32'hf0e1_d2c3, 32'hb4a5_9687, 32'h7869_5a4b,
              32'h3c2d_1e0f, 32'h0123_4567, 32'h89ab_cdef};
      ids3 = ~ids;

      m_state = S_TLR; m_irsr = '0; m_ir = '0; m_dr = '0; m_tdo = 1'b0;
      exp_cnt = 0; exp_data = '0; exp_sel = 1'b0;

      rst_n = 1'b0; trst_n = 1'b1; tck = 1'b0; tms = 1'b1; tdi = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(tdo === 1'b0, "R10 tdo after reset", 256'(tdo), 256'(0));
      chk(cfg_valid === 1'b0 && cfg_data === '0 && cfg_sel === 1'b0,
          "R10 cfg outputs after reset", 256'({cfg_valid, cfg_sel, cfg_data}), 256'(0));

      // Stay in reset state, then idle; read the identity image
      tck_cycle(1, 0); tck_cycle(1, 0); tck_cycle(1, 0); tck_cycle(0, 0);
      scan_dr('0, 0, dout);
      chk(dout === layout(ids), "R6 identity image", 256'(dout), 256'(layout(ids)));
      chk(cfg_cnt == 0, "R10 reset instruction gives no strobe", 256'(cfg_cnt), 256'(0));

      scan_dr('0, 0, dout);
      chk(dout === '0, "R7 capture without reload", 256'(dout), 256'(0));

      scan_ir(OP_C0, io);
      chk(io === 46'h1, "R3 capture pattern with upper bits kept", 256'(io), 256'(46'h1));

      scan_dr(d1, 0, dout);
      chk(cfg_cnt == 1 && cfg_last === d1[196:155] && cfg_last_sel === 1'b0,
          "R8 opcode 0 word", 256'({cfg_last_sel, cfg_last}), 256'({1'b0, d1[196:155]}));

      scan_ir(OP_C1, io);
      chk(io === {OP_C0[45:2], 2'b01}, "R5 previous instruction read back",
          256'(io), 256'({OP_C0[45:2], 2'b01}));

      scan_dr(d2, 1, dout);
      chk(dout === d1, "R4 shift order through pause", 256'(dout), 256'(d1));
      chk(cfg_cnt == 2 && cfg_last === d2[196:155] && cfg_last_sel === 1'b1,
          "R8 opcode 1 word", 256'({cfg_last_sel, cfg_last}), 256'({1'b1, d2[196:155]}));

      // R2: toggle tms and tdi while tck stays high
      tdo_before = tdo; cnt_before = cfg_cnt;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         tms = ~tms; tdi = ~tdi;
      end
      repeat (4) @(negedge clk);
      chk(tdo === tdo_before && cfg_cnt == cnt_before, "R2 no edge no change",
          256'({tdo, cfg_cnt[7:0]}), 256'({tdo_before, cnt_before[7:0]}));

      // R1: Select-DR, Select-IR, reset state, then idle loads new codes
      tck_cycle(1, 0); tck_cycle(1, 0); tck_cycle(1, 0);
      ids = ids2;
      tck_cycle(0, 0);
      scan_dr('0, 0, dout);
      chk(dout === layout(ids2), "R1 Select-IR escape to reset", 256'(dout), 256'(layout(ids2)));

      scan_ir(OP_ID, io);
      ids = ids3;
      cnt_before = cfg_cnt;
      scan_dr(d1, 0, dout);
      chk(dout === layout(ids3), "R7 reload on capture", 256'(dout), 256'(layout(ids3)));
      chk(cfg_cnt == cnt_before, "R8 other opcode no strobe", 256'(cfg_cnt), 256'(cnt_before));

      scan_ir(OP_C0 ^ (46'h1 << 45), io);
      scan_dr('0, 0, dout);
      chk(dout === d1, "R7 near-miss opcode no reload", 256'(dout), 256'(d1));
      chk(cfg_cnt == cnt_before, "R5 near-miss opcode no strobe", 256'(cfg_cnt), 256'(cnt_before));

      // R9: test reset in the middle of an instruction scan
      scan_ir(OP_C1, io);
      tck_cycle(1, 0); tck_cycle(1, 0); tck_cycle(0, 0); tck_cycle(0, 0);
      for (int i = 0; i < 10; i++) tck_cycle(0, 1);
      tdo_before = tdo;
      @(negedge clk); trst_n = 1'b0;
      repeat (6) @(negedge clk);
      trst_n = 1'b1;
      repeat (6) @(negedge clk);
      m_state = S_TLR;
      chk(tdo === tdo_before, "R9 tdo kept over test reset", 256'(tdo), 256'(tdo_before));
      tck_cycle(0, 0);
      cnt_before = cfg_cnt;
      scan_dr('0, 0, dout);
      chk(dout === layout(ids3), "R9 reset state reached", 256'(dout), 256'(layout(ids3)));
      chk(cfg_cnt == cnt_before + 1 && cfg_last_sel === 1'b1,
          "R9 instruction kept over test reset", 256'({cfg_last_sel, cfg_cnt[7:0]}),
          256'({1'b1, 8'(cnt_before + 1)}));

      done = 1;
      summary();
      $finish;
   end
endmodule